// File: doc/BRIEF.md
# Streaming Pairwise Minimum and Maximum Finder

The block takes a sequence of signed integers as a stream of element pairs and reports the smallest and largest value once the sequence ends. Each accepted pair is put in order by a single comparator. Only the larger element is then compared with the running maximum, and only the smaller element with the running minimum. A sequence of N elements therefore needs about 3N/2 comparisons instead of the 2N that two separate searches would use.

A producer presents one pair per beat on `in_a`/`in_b` and marks the final pair with `in_last`. When the sequence has an odd number of elements, the producer also raises `in_odd` on that final pair. The block then treats `in_a` as both members and ignores `in_b`. The first pair of every sequence loads the running extremes directly from its ordered members, so no results carry over from the previous sequence.

The input follows valid/ready rules: a beat transfers on a rising edge where `in_valid` and `in_ready` are both high. The block never applies back-pressure. `in_ready` rises on the first edge after reset is released and then stays high. A producer may still insert idle cycles by holding `in_valid` low. One cycle after the last pair transfers, `out_done` pulses for one cycle, and at that point `out_min`/`out_max` hold the results. These values stay unchanged until the next pair transfers.

Top module: `minmax_pair_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `out_min` and `out_max` are 0 and `out_done` is 0.
- R2: `in_ready` is 1 in every cycle after the first rising edge with `rst_n` high and never drops before the next reset.
- R3: For every transferred pair, the larger member takes part only in the maximum search and the smaller only in the minimum search, so at `out_done` `out_max` is the largest and `out_min` the smallest element of the sequence.
- R4: The first pair after reset or after a transferred `in_last` pair sets the extremes to its own members and ignores all values of earlier sequences.
- R5: A later pair changes `out_max` only when its larger member is strictly greater, and changes `out_min` only when its smaller member is strictly smaller.
- R6: When `in_last` and `in_odd` are both 1 on a transferred pair, `in_b` is ignored and `in_a` is used as both members.
- R7: `in_odd` has no effect on a pair with `in_last` at 0; both members count.
- R8: `out_done` is 1 in exactly the cycle after a transfer with `in_last` at 1, and 0 in all other cycles.
- R9: `out_min` and `out_max` change only on the edge that follows a transferred pair; idle cycles leave them unchanged.
- R10: Values on `in_a`, `in_b`, `in_last` and `in_odd` while `in_valid` is 0 have no effect.
- R11: Comparisons use two's complement signed order over `DATA_W` bits (default 16), so -32768 is below every other value and 32767 above.
- R12: A sequence consisting of a single pair yields the smaller member as `out_min` and the larger as `out_max`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pair is offered |
| in_ready | output | 1 | Block can take a pair (high after reset) |
| in_a | input | DATA_W | First member of the pair, signed |
| in_b | input | DATA_W | Second member of the pair, signed |
| in_last | input | 1 | This pair ends the sequence |
| in_odd | input | 1 | With `in_last`: only `in_a` is a real element |
| out_min | output | DATA_W | Running and final minimum, signed |
| out_max | output | DATA_W | Running and final maximum, signed |
| out_done | output | 1 | One-cycle pulse: final results valid |

## Verification
A swapped or missing pair comparison would push a smaller member into the maximum search, and the error would show in `out_max` or `out_min` at the next `out_done` pulse. A stale start-of-sequence flag would merge extremes across sequences, so back-to-back sequences with disjoint value ranges expose it one pulse later. An unsigned comparison, or a wrong choice of the second member on odd endings, changes the reported extreme in the very next result. A wrong update enable shows as moving outputs during idle cycles, one edge after the idle beat.

// File: rtl/minmax_pkg.sv
package minmax_pkg;
  // Which extreme a tracker keeps.
  typedef enum logic [0:0] {
    TRACK_MAX = 1'b0,
    TRACK_MIN = 1'b1
  } track_mode_e;

  localparam int unsigned DEF_DATA_W = 16;
endpackage

// File: rtl/minmax_pair_sorter.sv
// Orders one pair with a single signed comparator.
module minmax_pair_sorter #(
  parameter int unsigned DATA_W = minmax_pkg::DEF_DATA_W
) (
  input  logic signed [DATA_W-1:0] x,
  input  logic signed [DATA_W-1:0] y,
  output logic signed [DATA_W-1:0] hi,
  output logic signed [DATA_W-1:0] lo
);
  logic x_gt_y;

  always_comb begin
    x_gt_y = (x > y);
    hi = x_gt_y ? x : y;
    lo = x_gt_y ? y : x;
  end
endmodule

// File: rtl/minmax_tracker.sv
// Keeps one running extreme; the mode picks the comparison direction.
module minmax_tracker
  import minmax_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter track_mode_e MODE   = TRACK_MAX
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic                     restart,
  input  logic signed [DATA_W-1:0] cand,
  output logic signed [DATA_W-1:0] best
);
  logic better;

  generate
    if (MODE == TRACK_MAX) begin : g_max
      always_comb better = (cand > best);
    end else begin : g_min
      always_comb better = (cand < best);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best <= '0;
    end else if (upd && (restart || better)) begin
      best <= cand;
    end
  end
endmodule

// File: rtl/minmax_seq_ctrl.sv
// Tracks sequence boundaries, the ready flag and the done pulse.
module minmax_seq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer,
  input  logic last,
  output logic ready,
  output logic first,
  output logic done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready <= 1'b0;
      first <= 1'b1;
      done  <= 1'b0;
    end else begin
      ready <= 1'b1;
      done  <= xfer && last;
      if (xfer) begin
        first <= last;
      end
    end
  end
endmodule

// File: rtl/minmax_pair_top.sv
module minmax_pair_top
  import minmax_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_a,
  input  logic signed [DATA_W-1:0] in_b,
  input  logic                     in_last,
  input  logic                     in_odd,
  output logic signed [DATA_W-1:0] out_min,
  output logic signed [DATA_W-1:0] out_max,
  output logic                     out_done
);
  logic                     xfer;
  logic                     first;
  logic signed [DATA_W-1:0] b_eff;
  logic signed [DATA_W-1:0] pair_hi;
  logic signed [DATA_W-1:0] pair_lo;

  assign xfer  = in_valid && in_ready;
  // A single trailing element stands in for both members.
  assign b_eff = (in_last && in_odd) ? in_a : in_b;

  minmax_seq_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .xfer  (xfer),
    .last  (in_last),
    .ready (in_ready),
    .first (first),
    .done  (out_done)
  );

  minmax_pair_sorter #(.DATA_W(DATA_W)) u_sort (
    .x  (in_a),
    .y  (b_eff),
    .hi (pair_hi),
    .lo (pair_lo)
  );

  minmax_tracker #(.DATA_W(DATA_W), .MODE(TRACK_MAX)) u_max (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (xfer),
    .restart (first),
    .cand    (pair_hi),
    .best    (out_max)
  );

  minmax_tracker #(.DATA_W(DATA_W), .MODE(TRACK_MIN)) u_min (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (xfer),
    .restart (first),
    .cand    (pair_lo),
    .best    (out_min)
  );
endmodule

// File: rtl/minmax_pair_chk.sv
module minmax_pair_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     in_last,
  input logic signed [DATA_W-1:0] out_min,
  input logic signed [DATA_W-1:0] out_max,
  input logic                     out_done
);
  logic acc;
  logic mid_q;

  assign acc = in_valid && in_ready;

  // Set while a sequence has started and not yet ended.
  always_ff @(posedge clk) begin
    if (!rst_n) mid_q <= 1'b0;
    else if (acc) mid_q <= !in_last;
  end

  // R2
  ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  // R8
  done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_last) |=> out_done);

  // R8
  done_only_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && in_last) |=> !out_done);

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(out_min) && $stable(out_max)));

  // R3
  min_not_above_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_min <= out_max));

  // R5
  max_never_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mid_q) |=> (out_max >= $past(out_max)));

  // R5
  min_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mid_q) |=> (out_min <= $past(out_min)));
endmodule

bind minmax_pair_top minmax_pair_chk #(.DATA_W(DATA_W)) u_minmax_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_last  (in_last),
  .out_min  (out_min),
  .out_max  (out_max),
  .out_done (out_done)
);

// File: tb/test_minmax_pair_top.sv
module test_minmax_pair_top;
  localparam int W = 16;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid;
  logic                in_ready;
  logic signed [W-1:0] in_a;
  logic signed [W-1:0] in_b;
  logic                in_last;
  logic                in_odd;
  logic signed [W-1:0] out_min;
  logic signed [W-1:0] out_max;
  logic                out_done;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  int signed vals [0:63];
  int        nvals;

  always #10 clk = ~clk;

  minmax_pair_top #(.DATA_W(W)) i_minmax_pair_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_last(in_last), .in_odd(in_odd),
    .out_min(out_min), .out_max(out_max), .out_done(out_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int seq_min();
    int m = vals[0];
    for (int i = 1; i < nvals; i++) if (vals[i] < m) m = vals[i];
    return m;
  endfunction

  function automatic int seq_max();
    int m = vals[0];
    for (int i = 1; i < nvals; i++) if (vals[i] > m) m = vals[i];
    return m;
  endfunction

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  // Idle beat with garbage on the data pins (R10); outputs must not move (R9).
  task automatic idle_beat();
    int pmin, pmax;
    pmin = out_min; pmax = out_max;
    in_valid = 1'b0;
    in_a = W'(rnd16()); in_b = W'(rnd16());
    in_last = 1'($urandom); in_odd = 1'($urandom);
    @(negedge clk);
    chk(out_min == pmin, "R10 min unchanged on idle", out_min, pmin);
    chk(out_max == pmax, "R9 max unchanged on idle", out_max, pmax);
    chk(out_done == 1'b0, "R8 no done on idle", out_done, 0);
  endtask

  // Sends vals[0..nvals-1] as pairs, optional idle gaps, then checks results.
  task automatic run_seq(input bit gaps, input string tag);
    int npairs, emin, emax;
    bit odd;
    npairs = (nvals + 1) / 2;
    odd    = (nvals % 2) == 1;
    emin = seq_min(); emax = seq_max();
    for (int p = 0; p < npairs; p++) begin
      bit lastp;
      lastp = (p == npairs - 1);
      in_valid = 1'b1;
      in_a     = W'(vals[2*p]);
      in_last  = lastp;
      if (lastp && odd) begin
        in_odd = 1'b1;
        in_b   = W'(rnd16());            // must be ignored (R6)
      end else begin
        in_b   = W'(vals[2*p+1]);
        in_odd = lastp ? 1'b0 : 1'($urandom); // no effect mid-sequence (R7)
      end
      @(negedge clk);
      if (!lastp) begin
        chk(out_done == 1'b0, "R8 no done mid-sequence", out_done, 0);
        if (gaps && ($urandom % 3 == 0)) idle_beat();
      end
    end
    chk(out_done == 1'b1, {"R8 done after last ", tag}, out_done, 1);
    chk(out_min == emin, {"R3 R6 R7 R11 min ", tag}, out_min, emin);
    chk(out_max == emax, {"R3 R6 R7 R11 max ", tag}, out_max, emax);
    in_valid = 1'b0;
    in_last  = 1'b0;
    @(negedge clk);
    chk(out_done == 1'b0, {"R8 done is one cycle ", tag}, out_done, 0);
    chk(out_min == emin && out_max == emax, {"R9 results held ", tag}, out_min, emin);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; in_last = 1'b0; in_odd = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_min == 0 && out_max == 0, "R1 outputs zero in reset", out_max, 0);
    chk(out_done == 1'b0, "R1 done low in reset", out_done, 0);
    chk(in_ready == 1'b0, "R2 ready low in reset", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_min == 0 && out_max == 0 && out_done == 0, "R1 outputs zero after reset", out_max, 0);
    chk(in_ready == 1'b1, "R2 ready high after reset", in_ready, 1);

    // R12: single pair, both orders
    vals[0] = 100; vals[1] = -5; nvals = 2; run_seq(0, "R12 single pair");
    vals[0] = -7; vals[1] = 9; nvals = 2; run_seq(0, "R12 swapped pair");
    // R6: single odd element, in_b garbage
    vals[0] = 1234; nvals = 1; run_seq(0, "R6 lone element");
    // R11: full-range extremes
    vals[0] = 32767; vals[1] = -32768; vals[2] = -1; vals[3] = 0; nvals = 4;
    run_seq(0, "R11 extremes");
    // R4: large values then disjoint small range, back to back
    for (int i = 0; i < 6; i++) vals[i] = 30000 + i;
    nvals = 6; run_seq(0, "R4 high range");
    for (int i = 0; i < 5; i++) vals[i] = -20000 - 3 * i;
    nvals = 5; run_seq(0, "R4 low range odd");
    // R5: all equal, then strictly ascending / descending
    for (int i = 0; i < 8; i++) vals[i] = -42;
    nvals = 8; run_seq(1, "R5 equal");
    for (int i = 0; i < 9; i++) vals[i] = i * 1000 - 4000;
    nvals = 9; run_seq(1, "R5 ascending");
    for (int i = 0; i < 10; i++) vals[i] = 5000 - i * 777;
    nvals = 10; run_seq(0, "R5 descending");

    // Random sequences with gaps
    for (int s = 0; s < 40; s++) begin
      nvals = 1 + int'($urandom % 64);
      for (int i = 0; i < nvals; i++) vals[i] = rnd16();
      run_seq(1, "random");
    end

    idle_beat();
    chk(in_ready == 1'b1, "R2 ready stays high", in_ready, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule